// File: doc/BRIEF.md
# Multi-Voice Key Start/Release Controller

This block holds the key state for a bank of sample-playback voices (eight by default). A controller writes bytes into four small registers: a key-on register, a key-off register, an end-flag register and a control register. From those writes the block produces a one-cycle start pulse and a one-cycle release pulse per voice, and it keeps a mask of the voices that are currently keyed. The voice engines that play samples sit outside the block. They take the pulses, and each one reports back with a one-cycle end-of-sample pulse that sets its end flag.

The key-on and key-off registers interact. A key-on for a voice whose key-off bit is still set does not start that voice. The start is held as pending and is launched when a later key-off write clears that bit. When the control byte is written with its top bit set, all key state is wiped and every keyed voice is released.

Top module: `voice_key_ctrl`

## Requirements
- R1: After synchronous reset the keyed mask, key-on, key-off and end-flag registers are all zero, no pulse is active, and the control register holds 0xC0.
- R2: A key-on write (select 0) of a set bit n while key-off bit n is clear drives start pulse n high for exactly the next cycle, sets keyed bit n and clears end flag n.
- R3: A key-on write of a set bit n while key-off bit n is set issues no start pulse, leaves keyed bit n unchanged and records a pending start for voice n.
- R4: A key-off write (select 1) with bit n set on a keyed voice n drives release pulse n for one cycle, clears keyed bit n, clears key-on register bit n and drops any pending start of voice n.
- R5: A key-off write with bit n clear while voice n has a pending start drives start pulse n for one cycle, sets keyed bit n and clears end flag n.
- R6: A key-off write stores its data byte as the new key-off register contents.
- R7: Any write to the end-flag register (select 2) clears all end flags, whatever the data byte holds.
- R8: An end-of-sample pulse on voice n sets end flag n. If voice n starts in the same cycle, the start wins and the flag ends up clear.
- R9: A control write (select 3) with bit 7 set clears the key-on, key-off and end-flag registers, drops all pending starts, releases every keyed voice with one release pulse and empties the keyed mask. The control register then reads 0x60 OR the low 5 data bits, which forces bit 6 (mute) and bit 5 (echo disable) on and leaves bit 7 clear.
- R10: A control write with bit 7 clear stores the data byte unchanged.
- R11: A key-on write stores its data byte as the key-on register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 key-on, 1 key-off, 2 end-flag, 3 control |
| wr_data | input | 8 | Write data byte |
| voice_end | input | NUM_VOICES | Per-voice end-of-sample pulse |
| start_pulse | output | NUM_VOICES | One-cycle start request per voice |
| release_pulse | output | NUM_VOICES | One-cycle release request per voice |
| keyed_mask | output | NUM_VOICES | Voices currently keyed |
| keyon_reg | output | NUM_VOICES | Key-on register contents |
| keyoff_reg | output | NUM_VOICES | Key-off register contents |
| endflag_reg | output | NUM_VOICES | End-flag register contents |
| ctrl_reg | output | 8 | Control register contents |

## Verification
The pending start is the state that is hardest to reach. It cannot be seen at any port until it is launched, and a soft reset has to drop it without any trace. To reach it, the stimulus keys a voice off, keys it on again while its key-off bit is still set, and checks that no pulse appears. Clearing the key-off bit must then produce the delayed start. A second pending start is created just before a soft reset, and the bench checks that clearing key-off afterwards launches nothing. The start/end-flag collision is produced by raising the end-of-sample input during the key-on write cycle.

// File: rtl/voice_key_pkg.sv
// Package: shared register-select encoding for the voice key controller.
// Assumes a 2-bit select presented together with the write strobe.
package voice_key_pkg;
    typedef enum logic [1:0] {
        SEL_KEYON  = 2'd0,
        SEL_KEYOFF = 2'd1,
        SEL_ENDFLG = 2'd2,
        SEL_CTRL   = 2'd3
    } key_sel_e;

    localparam int unsigned CTRL_W      = 8;
    localparam int unsigned CTRL_SRST   = 7;
    localparam int unsigned CTRL_MUTE   = 6;
    localparam int unsigned CTRL_ECHOFF = 5;
    localparam int unsigned CTRL_LOW_W  = 5;
endpackage

// File: rtl/voice_key_decode.sv
// Module: turns one write strobe plus select into per-register write enables.
// Assumes at most one register is written per cycle; the soft-reset enable
// fires only on a control write whose top data bit is set.
module voice_key_decode
    import voice_key_pkg::*;
(
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic         srst_bit,
    output logic         we_keyon,
    output logic         we_keyoff,
    output logic         we_endflg,
    output logic         we_ctrl,
    output logic         soft_rst
);
    // Decode the select into one-hot write enables.
    always_comb begin
        we_keyon  = wr_en && (key_sel_e'(wr_sel) == SEL_KEYON);
        we_keyoff = wr_en && (key_sel_e'(wr_sel) == SEL_KEYOFF);
        we_endflg = wr_en && (key_sel_e'(wr_sel) == SEL_ENDFLG);
        we_ctrl   = wr_en && (key_sel_e'(wr_sel) == SEL_CTRL);
        soft_rst  = we_ctrl && srst_bit;
    end
endmodule

// File: rtl/voice_key_slice.sv
// Module: key state of a single voice (keyed, pending start, key-on bit,
// key-off bit, end flag) plus its registered start and release pulses.
// Assumes the write enables it receives are mutually exclusive.
module voice_key_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic we_keyon,
    input  logic we_keyoff,
    input  logic we_endflg,
    input  logic soft_rst,
    input  logic data_bit,
    input  logic end_in,
    output logic start_q,
    output logic release_q,
    output logic keyed_q,
    output logic keyon_q,
    output logic keyoff_q,
    output logic endflg_q
);
    logic pend_q;
    logic go;
    logic kill;
    logic hold;

    // Work out whether this write starts, releases or defers the voice.
    always_comb begin
        go   = (we_keyon && data_bit && !keyoff_q) ||
               (we_keyoff && !data_bit && pend_q);
        hold = we_keyon && data_bit && keyoff_q;
        kill = (we_keyoff && data_bit && keyed_q) || (soft_rst && keyed_q);
    end

    // Update the voice state and register the one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keyed_q   <= 1'b0;
            pend_q    <= 1'b0;
            keyon_q   <= 1'b0;
            keyoff_q  <= 1'b0;
            endflg_q  <= 1'b0;
            start_q   <= 1'b0;
            release_q <= 1'b0;
        end else begin
            start_q   <= go;
            release_q <= kill;
            if (soft_rst || kill)   keyed_q <= 1'b0;
            else if (go)            keyed_q <= 1'b1;
            if (soft_rst || kill || go) pend_q <= 1'b0;
            else if (hold)              pend_q <= 1'b1;
            if (soft_rst || kill)   keyon_q <= 1'b0;
            else if (we_keyon)      keyon_q <= data_bit;
            if (soft_rst)           keyoff_q <= 1'b0;
            else if (we_keyoff)     keyoff_q <= data_bit;
            if (go)                 endflg_q <= 1'b0;
            else if (soft_rst || we_endflg) endflg_q <= end_in;
            else                    endflg_q <= endflg_q | end_in;
        end
    end

    // R2
    pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_q && release_q));
    // R2
    start_marks_keyed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_q |-> (keyed_q && !endflg_q));
    // R4
    release_unkeys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_q |-> !keyed_q);
    // R3
    pending_needs_keyoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> keyoff_q);
    // R3
    deferred_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_keyon && data_bit && keyoff_q) |=> !start_q);
endmodule

// File: rtl/voice_key_ctrl.sv
// Module: top of the multi-voice key controller. Holds the control register,
// decodes register writes and instantiates one key slice per voice.
// Assumes voice_end pulses are synchronous to clk.
module voice_key_ctrl
    import voice_key_pkg::*;
#(
    parameter int unsigned NUM_VOICES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [7:0]            wr_data,
    input  logic [NUM_VOICES-1:0] voice_end,
    output logic [NUM_VOICES-1:0] start_pulse,
    output logic [NUM_VOICES-1:0] release_pulse,
    output logic [NUM_VOICES-1:0] keyed_mask,
    output logic [NUM_VOICES-1:0] keyon_reg,
    output logic [NUM_VOICES-1:0] keyoff_reg,
    output logic [NUM_VOICES-1:0] endflag_reg,
    output logic [7:0]            ctrl_reg
);
    localparam logic [CTRL_W-1:0] CTRL_RST_VAL =
        CTRL_W'((1 << CTRL_SRST) | (1 << CTRL_MUTE));
    localparam logic [CTRL_W-1:0] CTRL_FORCE =
        CTRL_W'((1 << CTRL_MUTE) | (1 << CTRL_ECHOFF));

    logic we_keyon, we_keyoff, we_endflg, we_ctrl, soft_rst;

    voice_key_decode dec_i (
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .srst_bit  (wr_data[CTRL_SRST]),
        .we_keyon  (we_keyon),
        .we_keyoff (we_keyoff),
        .we_endflg (we_endflg),
        .we_ctrl   (we_ctrl),
        .soft_rst  (soft_rst)
    );

    // Control register: plain store, or forced flags after a soft reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_reg <= CTRL_RST_VAL;
        else if (soft_rst)
            ctrl_reg <= CTRL_FORCE | {{(CTRL_W-CTRL_LOW_W){1'b0}}, wr_data[CTRL_LOW_W-1:0]};
        else if (we_ctrl)
            ctrl_reg <= wr_data;
    end

    for (genvar v = 0; v < NUM_VOICES; v++) begin : g_voice
        voice_key_slice slice_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_keyon  (we_keyon),
            .we_keyoff (we_keyoff),
            .we_endflg (we_endflg),
            .soft_rst  (soft_rst),
            .data_bit  (wr_data[v]),
            .end_in    (voice_end[v]),
            .start_q   (start_pulse[v]),
            .release_q (release_pulse[v]),
            .keyed_q   (keyed_mask[v]),
            .keyon_q   (keyon_reg[v]),
            .keyoff_q  (keyoff_reg[v]),
            .endflg_q  (endflag_reg[v])
        );
    end

    // R9
    soft_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (keyed_mask == '0 && keyoff_reg == '0 && keyon_reg == '0
                      && ctrl_reg[CTRL_MUTE] && ctrl_reg[CTRL_ECHOFF]
                      && !ctrl_reg[CTRL_SRST]));
    // R9
    soft_rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (release_pulse == $past(keyed_mask)));
    // R6
    keyoff_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_keyoff |=> (keyoff_reg == $past(wr_data[NUM_VOICES-1:0])));
    // R7
    endflag_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_endflg && voice_end == '0) |=> (endflag_reg == '0));
endmodule

// File: tb/voice_key_ctrl_tb.sv
// Testbench: directed scenarios, one task each, self-checking via counters.
module voice_key_ctrl_tb_top;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [7:0]    wr_data = '0;
    logic [NV-1:0] voice_end = '0;
    logic [NV-1:0] start_pulse, release_pulse, keyed_mask;
    logic [NV-1:0] keyon_reg, keyoff_reg, endflag_reg;
    logic [7:0]    ctrl_reg;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    voice_key_ctrl #(.NUM_VOICES(NV)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .voice_end(voice_end),
        .start_pulse(start_pulse), .release_pulse(release_pulse),
        .keyed_mask(keyed_mask), .keyon_reg(keyon_reg),
        .keyoff_reg(keyoff_reg), .endflag_reg(endflag_reg),
        .ctrl_reg(ctrl_reg)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write cycle, optionally with end pulses; returns at the negedge
    // after the capturing edge, where the registered pulses are visible.
    task automatic wr(input logic [1:0] sel, input logic [7:0] d, input logic [NV-1:0] ends);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; voice_end = ends;
        @(negedge clk);
        wr_en = 1'b0; voice_end = '0;
    endtask

    task automatic pulse_end(input logic [NV-1:0] ends);
        @(negedge clk);
        voice_end = ends;
        @(negedge clk);
        voice_end = '0;
    endtask

    task automatic t_reset;
        chk("R1 keyed", keyed_mask, 8'h00);
        chk("R1 ctrl", ctrl_reg, 8'hC0);
        chk("R1 keyon", keyon_reg, 8'h00);
        chk("R1 keyoff", keyoff_reg, 8'h00);
        chk("R1 endflag", endflag_reg, 8'h00);
        chk("R1 start", start_pulse, 8'h00);
        chk("R1 release", release_pulse, 8'h00);
    endtask

    task automatic t_keyon;
        pulse_end(8'h0F);
        chk("R8 end sets", endflag_reg, 8'h0F);
        wr(2'd0, 8'h05, '0);
        chk("R2 start", start_pulse, 8'h05);
        chk("R2 keyed", keyed_mask, 8'h05);
        chk("R2 endflag cleared", endflag_reg, 8'h0A);
        chk("R11 keyon store", keyon_reg, 8'h05);
        @(negedge clk);
        chk("R2 one cycle", start_pulse, 8'h00);
        wr(2'd0, 8'h02, 8'h02);
        chk("R8 start wins", endflag_reg, 8'h08);
        chk("R8 keyed", keyed_mask, 8'h07);
        chk("R11 keyon overwrite", keyon_reg, 8'h02);
    endtask

    task automatic t_keyoff;
        wr(2'd1, 8'h01, '0);
        chk("R4 release", release_pulse, 8'h01);
        chk("R4 keyed", keyed_mask, 8'h06);
        chk("R6 keyoff store", keyoff_reg, 8'h01);
        @(negedge clk);
        chk("R4 one cycle", release_pulse, 8'h00);
        wr(2'd0, 8'h03, '0);
        chk("R4 keyon bit cleared", keyon_reg, 8'h03);
    endtask

    task automatic t_pending;
        chk("R3 no start", start_pulse, 8'h02);
        chk("R3 keyed", keyed_mask, 8'h06);
        @(negedge clk);
        wr(2'd1, 8'h00, '0);
        chk("R5 delayed start", start_pulse, 8'h01);
        chk("R5 keyed", keyed_mask, 8'h07);
        chk("R5 no release", release_pulse, 8'h00);
        chk("R6 keyoff zero", keyoff_reg, 8'h00);
    endtask

    task automatic t_endflag;
        pulse_end(8'hF0);
        chk("R8 end upper", endflag_reg, 8'hF8);
        wr(2'd2, 8'hFF, '0);
        chk("R7 wipe", endflag_reg, 8'h00);
    endtask

    task automatic t_ctrl;
        wr(2'd3, 8'h1F, '0);
        chk("R10 plain store", ctrl_reg, 8'h1F);
        chk("R10 keyed kept", keyed_mask, 8'h07);
    endtask

    task automatic t_soft;
        wr(2'd1, 8'h80, '0);
        chk("R4 unkeyed no release", release_pulse, 8'h00);
        wr(2'd0, 8'h80, '0);
        chk("R3 pending voice7", start_pulse, 8'h00);
        pulse_end(8'h10);
        wr(2'd3, 8'h8A, '0);
        chk("R9 release all", release_pulse, 8'h07);
        chk("R9 keyed", keyed_mask, 8'h00);
        chk("R9 ctrl", ctrl_reg, 8'h6A);
        chk("R9 keyoff", keyoff_reg, 8'h00);
        chk("R9 keyon", keyon_reg, 8'h00);
        chk("R9 endflag", endflag_reg, 8'h00);
        wr(2'd1, 8'h00, '0);
        chk("R9 pending dropped", start_pulse, 8'h00);
        chk("R9 still unkeyed", keyed_mask, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_keyon();
        t_keyoff();
        t_pending();
        t_endflag();
        t_ctrl();
        t_soft();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule